// File: doc/BRIEF.md
# Cartridge PRG Bank Mapper with Cycle Timer Interrupt

This block turns CPU bus addresses of an 8-bit game cartridge into flat byte addresses of an 80 KiB program image, and raises an interrupt from a 12-bit timer that counts CPU cycles. The image has three parts. The lowest 64 KiB comes from a pair of 32 KiB devices. Above it sit four copies of a 2 KiB device, and the top 8 KiB holds a separate 8 KiB device. One 8 KiB CPU window is switchable. A 3-bit select register chooses the bank for it, and that value passes through a fixed, non-monotonic translation before it picks a bank. All other windows are fixed.

The CPU writes the select register and the timer control register over the bus. A one-cycle write strobe qualifies each write, and the address is decoded through a partial mask. The timer advances on every CPU-cycle pulse while it is enabled. When it wraps past its top value it latches an interrupt request, which stays set until software writes a zero control bit. A parameter picks between two board variants, which differ only in the address of the timer control register.

Top module: `prg_bank_irq_mapper`

## Requirements
- R1: After reset the select register holds 0, the timer is disabled with its count at 0, and `irq` is low.
- R2: A write changes the select register only when (`cpu_addr` AND 0x71FF) equals 0x4022. Only data bits 2..0 are stored, and writes to any other address leave it unchanged.
- R3: The stored select value v maps to an 8 KiB bank as follows: 0 and 2 to 4 give bank 4, 1 gives 3, 5 gives 7, 6 gives 5 and 7 gives 6. CPU 0xC000-0xDFFF reads `bank*0x2000 + (addr AND 0x1FFF)`.
- R4: CPU 0xA000-0xBFFF uses bank 0, 0x8000-0x9FFF uses bank 1 and 0x6000-0x7FFF uses bank 2. Each flat address is `bank*0x2000 + (addr AND 0x1FFF)`.
- R5: CPU 0x5000-0x5FFF gives `0x10000 + (addr AND 0x7FF)`, so the 2 KiB device appears twice in that range.
- R6: CPU 0xE000-0xFFFF gives `0x12000 + (addr AND 0x1FFF)`.
- R7: For CPU addresses below 0x5000, `rom_sel` is low and `rom_addr` is 0. For all other addresses `rom_sel` is high.
- R8: The timer control register responds when (`cpu_addr` AND 0x71FF) equals 0x4122 with `IRQ_HI_ADDR`=0, and 0x0122 (the mask applied to 0x8122) with `IRQ_HI_ADDR`=1. Only data bit 0 matters, and a 1 there enables counting without changing the count.
- R9: While enabled, the count rises by one on each cycle with `m2_pulse` high. With `m2_pulse` low, or with the timer disabled, the count holds. The 4096th pulse counted from 0 sets `irq`.
- R10: `irq` stays high after an overflow, and the count wraps to 0 and keeps running. Further overflows leave `irq` high.
- R11: A control write with bit 0 = 0 clears `irq`, disables the timer and zeroes the count. It takes priority over an `m2_pulse` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; every register updates on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | One-cycle write strobe |
| m2_pulse | input | 1 | One-cycle pulse per CPU cycle |
| rom_addr | output | 17 | Flat byte address into the 80 KiB program image |
| rom_sel | output | 1 | High when the address falls in a mapped window |
| irq | output | 1 | Latched interrupt request, active high |

## Verification
A wrong select value or translation entry appears at once on `rom_addr` for every address in 0xC000-0xDFFF. A full address sweep for each of the eight select values exposes it in the same cycle as the write that caused it. A count that is off by any amount shifts the cycle in which `irq` rises, so the bench checks `irq` one pulse before and one pulse after the expected overflow. A missed clear or a lost enable shows up as `irq` rising early, late or never within the next 4096 pulses.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  localparam int CPU_AW   = 16;
  localparam int ROM_AW   = 17;
  localparam int SEL_W    = 3;
  localparam int BANK_W   = 3;
  localparam int WIN_AW   = 13;
  localparam int MINI_AW  = 11;
  localparam logic [CPU_AW-1:0] DEC_MASK  = 16'h71FF;
  localparam logic [CPU_AW-1:0] SEL_ADDR  = 16'h4022;
  localparam logic [ROM_AW-1:0] MINI_BASE = 17'h10000;
  localparam logic [ROM_AW-1:0] TOP_BASE  = 17'h12000;

  typedef enum logic [2:0] {
    WIN_NONE, WIN_MINI, WIN_FIXED, WIN_SWITCH, WIN_TOP
  } win_e;

  function automatic logic [BANK_W-1:0] xlate_bank(input logic [SEL_W-1:0] v);
    case (v)
      3'd1:    xlate_bank = 3'd3;
      3'd5:    xlate_bank = 3'd7;
      3'd6:    xlate_bank = 3'd5;
      3'd7:    xlate_bank = 3'd6;
      default: xlate_bank = 3'd4;
    endcase
  endfunction

  function automatic win_e classify(input logic [CPU_AW-1:0] a);
    case (a[15:12])
      4'h5:                      classify = WIN_MINI;
      4'h6, 4'h7, 4'h8, 4'h9,
      4'hA, 4'hB:                classify = WIN_FIXED;
      4'hC, 4'hD:                classify = WIN_SWITCH;
      4'hE, 4'hF:                classify = WIN_TOP;
      default:                   classify = WIN_NONE;
    endcase
  endfunction

  // fixed banks: 0x6000 -> 2, 0x8000 -> 1, 0xA000 -> 0
  function automatic logic [BANK_W-1:0] fixed_bank(input logic [CPU_AW-1:0] a);
    case (a[15:13])
      3'd3:    fixed_bank = 3'd2;
      3'd4:    fixed_bank = 3'd1;
      default: fixed_bank = 3'd0;
    endcase
  endfunction

  function automatic logic [ROM_AW-1:0] bank_addr(input logic [BANK_W-1:0] b,
                                                  input logic [CPU_AW-1:0] a);
    bank_addr = {1'b0, b, a[WIN_AW-1:0]};
  endfunction
endpackage

// File: rtl/pbm_bank_reg.sv
module pbm_bank_reg
  import pbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic              cpu_wr,
  output logic [BANK_W-1:0] sw_bank
);
  logic             sel_hit;
  logic [SEL_W-1:0] sel_q;

  assign sel_hit = cpu_wr && ((cpu_addr & DEC_MASK) == SEL_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)       sel_q <= '0;
    else if (sel_hit) sel_q <= cpu_data[SEL_W-1:0];
  end

  assign sw_bank = xlate_bank(sel_q);

  p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_hit |=> $stable(sel_q));
  p_bank_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |=> sel_q == $past(cpu_data[SEL_W-1:0]));
  p_bank_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_bank >= 3'd3);
endmodule

// File: rtl/pbm_addr_map.sv
module pbm_addr_map
  import pbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [BANK_W-1:0] sw_bank,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_sel
);
  win_e win;

  assign win = classify(cpu_addr);

  always_comb begin
    rom_sel  = 1'b1;
    rom_addr = '0;
    case (win)
      WIN_MINI:   rom_addr = MINI_BASE | {{(ROM_AW-MINI_AW){1'b0}}, cpu_addr[MINI_AW-1:0]};
      WIN_FIXED:  rom_addr = bank_addr(fixed_bank(cpu_addr), cpu_addr);
      WIN_SWITCH: rom_addr = bank_addr(sw_bank, cpu_addr);
      WIN_TOP:    rom_addr = TOP_BASE | {{(ROM_AW-WIN_AW){1'b0}}, cpu_addr[WIN_AW-1:0]};
      default:    rom_sel  = 1'b0;
    endcase
  end

  p_idle_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_sel |-> rom_addr == '0);
  p_in_image_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rom_addr < 17'h14000);
endmodule

// File: rtl/pbm_cycle_timer.sv
module pbm_cycle_timer
  import pbm_pkg::*;
#(
  parameter int          CNT_W    = 12,
  parameter logic [15:0] CTL_ADDR = 16'h4122
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              ctl_bit,
  input  logic              cpu_wr,
  input  logic              m2_pulse,
  output logic              irq
);
  localparam logic [CPU_AW-1:0] CTL_KEY = CTL_ADDR & DEC_MASK;
  localparam logic [CNT_W-1:0]  CNT_TOP = '1;

  logic             ctl_hit, ack_wr, arm_wr, step, wrap;
  logic             en_q, irq_q;
  logic [CNT_W-1:0] cnt_q;

  assign ctl_hit = cpu_wr && ((cpu_addr & DEC_MASK) == CTL_KEY);
  assign ack_wr  = ctl_hit && !ctl_bit;
  assign arm_wr  = ctl_hit && ctl_bit;
  assign step    = en_q && m2_pulse && !ack_wr;
  assign wrap    = step && (cnt_q == CNT_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (ack_wr) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (arm_wr) en_q <= 1'b1;
      if (step)   cnt_q <= cnt_q + 1'b1;
      if (wrap)   irq_q <= 1'b1;
    end
  end

  assign irq = irq_q;

  p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> !irq && cnt_q == '0 && !en_q);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q || !m2_pulse) && !ack_wr |=> $stable(cnt_q));
  p_irq_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack_wr |=> irq);
  p_irq_from_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cnt_q) == CNT_TOP && cnt_q == '0);
  p_arm_keeps_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arm_wr && !m2_pulse |=> en_q && $stable(cnt_q));
endmodule

// File: rtl/prg_bank_irq_mapper.sv
module prg_bank_irq_mapper
  import pbm_pkg::*;
#(
  parameter bit IRQ_HI_ADDR = 1'b0,
  parameter int TIMER_W     = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        cpu_wr,
  input  logic        m2_pulse,
  output logic [16:0] rom_addr,
  output logic        rom_sel,
  output logic        irq
);
  localparam logic [15:0] IRQ_CTL_ADDR = IRQ_HI_ADDR ? 16'h8122 : 16'h4122;

  logic [BANK_W-1:0] sw_bank;

  pbm_bank_reg u_bank (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .sw_bank(sw_bank)
  );

  pbm_addr_map u_map (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .sw_bank(sw_bank),
    .rom_addr(rom_addr), .rom_sel(rom_sel)
  );

  pbm_cycle_timer #(.CNT_W(TIMER_W), .CTL_ADDR(IRQ_CTL_ADDR)) u_timer (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .ctl_bit(cpu_data[0]),
    .cpu_wr(cpu_wr), .m2_pulse(m2_pulse), .irq(irq)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !irq);
endmodule

// File: tb/sim_prg_bank_irq_mapper.sv
module sim_prg_bank_irq_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0, wr1 = 1'b0;
  logic        m2_pulse = 1'b0;
  logic [16:0] rom_addr, rom_addr1;
  logic        rom_sel, rom_sel1, irq, irq1;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  prg_bank_irq_mapper u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .m2_pulse(m2_pulse), .rom_addr(rom_addr),
    .rom_sel(rom_sel), .irq(irq));

  prg_bank_irq_mapper #(.IRQ_HI_ADDR(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(wr1), .m2_pulse(m2_pulse), .rom_addr(rom_addr1),
    .rom_sel(rom_sel1), .irq(irq1));

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_bank(input int v);
    int tbl[8] = '{4, 3, 4, 4, 4, 7, 5, 6};
    return tbl[v];
  endfunction

  function automatic int exp_flat(input int a, input int v);
    int page = a / 8192;
    int off8 = a % 8192;
    if (a < 'h5000) return 0;
    if (a < 'h6000) return 65536 + (a % 2048);
    if (page == 3) return 2 * 8192 + off8;
    if (page == 4) return 1 * 8192 + off8;
    if (page == 5) return off8;
    if (page == 6) return exp_bank(v) * 8192 + off8;
    return 65536 + 8192 + off8;
  endfunction

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d, input bit to1 = 0);
    @(negedge clk);
    cpu_addr = a; cpu_data = d;
    if (to1) wr1 = 1'b1; else cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; wr1 = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      m2_pulse = 1'b1;
    end
    @(negedge clk);
    m2_pulse = 1'b0;
  endtask

  task automatic sweep(input int v, input string req);
    for (int a = 0; a < 65536; a++) begin
      cpu_addr = 16'(a);
      #1;
      check(req, rom_addr, exp_flat(a, v));
      check("R7", rom_sel, (a >= 'h5000) ? 1 : 0);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, select 0 -> bank 4
    check("R1 irq", irq, 0);
    cpu_addr = 16'hC123; #1;
    check("R1 bank", rom_addr, 4 * 8192 + 'h123);
    // R3 R4 R5 R6 R7: full sweep for every select value; odd values via mirrored address (R2)
    for (int v = 0; v < 8; v++) begin
      bus_wr((v % 2) ? 16'hC022 : 16'h4022, 8'(8'hF8 | v));
      sweep(v, "R3");
    end
    // R2: non-matching addresses ignored (select is 7 now -> bank 6)
    bus_wr(16'h4023, 8'h05);
    bus_wr(16'h4122, 8'h05);
    bus_wr(16'h8022, 8'h05);
    cpu_addr = 16'hD001; #1;
    check("R2 ignored", rom_addr, 6 * 8192 + 'h1001);
    bus_wr(16'h4022, 8'h05);
    cpu_addr = 16'hD001; #1;
    check("R2 load", rom_addr, 7 * 8192 + 'h1001);
    // R9: overflow at the 4096th pulse
    bus_wr(16'h4122, 8'h01);
    pulses(4095);
    check("R9 pre", irq, 0);
    pulses(1);
    check("R9 ovf", irq, 1);
    // R10: stays latched across wrap
    pulses(4096);
    check("R10 latched", irq, 1);
    // R11: ack with other bits set, bit0 = 0
    bus_wr(16'h4122, 8'hFE);
    check("R11 ack", irq, 0);
    pulses(5000);
    check("R11 disabled", irq, 0);
    // R8: wrong variant address ignored by u0
    bus_wr(16'h8122, 8'h01);
    pulses(4100);
    check("R8 wrong addr", irq, 0);
    // R8: arm write does not clear the count
    bus_wr(16'h4122, 8'h01);
    pulses(100);
    bus_wr(16'h4122, 8'h03);
    pulses(3995);
    check("R8 rearm pre", irq, 0);
    pulses(1);
    check("R8 rearm ovf", irq, 1);
    // R9: no pulses -> no count
    bus_wr(16'h4122, 8'h00);
    bus_wr(16'h4122, 8'h01);
    repeat (5000) @(negedge clk);
    check("R9 no pulse", irq, 0);
    // R11: ack wins over simultaneous pulse
    pulses(4095);
    @(negedge clk);
    cpu_addr = 16'h4122; cpu_data = 8'h00; cpu_wr = 1'b1; m2_pulse = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; m2_pulse = 1'b0;
    check("R11 priority", irq, 0);
    bus_wr(16'h4122, 8'h01);
    pulses(4095);
    check("R11 cleared cnt", irq, 0);
    pulses(1);
    check("R11 count restart", irq, 1);
    // R8: high-address variant
    check("R8 u1 idle", irq1, 0);
    bus_wr(16'h8122, 8'h01, 1);
    pulses(4095);
    check("R8 u1 pre", irq1, 0);
    pulses(1);
    check("R8 u1 ovf", irq1, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule